// File: doc/BRIEF.md
# Packet Page Allocator with Page Queues

This block manages a small pool of fixed-size packet pages for an Ethernet controller. It keeps a bitmap of the pages in use and carries out 3-bit memory-management commands written to a byte-wide register port. It maintains three short queues of page numbers: pages waiting to transmit, pages whose transmission is done, and pages holding received frames. It also holds the interrupt status and mask bytes and drives one level interrupt line. The packet memory and the line side are outside the block. A frame writer claims receive pages through a request/grant port.

Software allocates a page, fills it elsewhere, names it in the page-number register and enqueues it for transmit. The transmit side is modelled as completion one page per clock while transmit is enabled. A finished page is either freed at once (auto-release) or reported on the done queue until the interrupt acknowledge pops it. A transmit allocation that fails stays pending and is retried by itself once a page becomes free.

Top module: `pkt_page_mgr`

## Requirements
- R1: Allocation, whether by command or by a receive claim, takes the lowest-numbered free page of the four and marks it used. `rx_page` shows that page while `rx_grant` is high.
- R2: Command 1 (allocate for transmit) clears status bit 3. If a page is free, it writes the page number to the allocation-result register (address 2) and sets bit 3. Otherwise the result becomes 0x80 and bit 3 stays clear.
- R3: A write to address 0 issues a command taken from data bits 7:5: 0 none, 1 allocate, 2 full reset, 3 pop receive queue, 4 pop receive queue and free that page, 5 free the page in the page-number register (address 1, low two bits), 6 enqueue that page for transmit, 7 clear both transmit queues.
- R4: While the allocation result reads 0x80 and a page is free, the first clock with no register write performs the allocation: the result takes the page number and status bit 3 is set.
- R5: The status read at address 5 shows bit 2 whenever the transmit queue is empty and bit 1 whenever the done queue holds a page. Both bits also stay latched until acknowledged. The mask is at address 6, and `irq` is high exactly when status AND mask is nonzero.
- R6: A write to address 5 clears the status bits in (data AND 0xD6). If data bit 1 is set and the done queue is not empty, its head is removed. The done head reads at address 3.
- R7: Control at address 7 holds transmit-enable (bit 0) and auto-release (bit 1). While transmit is enabled, one queued page completes each clock. With auto-release set the page is freed. Otherwise it is appended to the done queue if that queue is not full.
- R8: Reading an empty done queue (address 3) or receive queue (address 4) returns 0x80. A receive pop removes the head, if any, and leaves bit 0 set only when entries remain.
- R9: Address 8 reads the number of used pages, address 9 reads 4, and address 0 reads 0 because every command finishes in one clock.
- R10: `rx_grant` is high when no register write is present, a page is free, the receive queue has room and no pending allocation is due. `rx_req` with `rx_grant` appends the page to the receive queue and sets status bit 0.
- R11: Command 2 frees all pages, empties all three queues and zeroes the allocation result. Command 7 empties only the transmit and done queues.
- R12: Writes to addresses other than 0, 1, 5, 6 and 7 have no effect, and reads of unlisted addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| rx_req | input | 1 | Frame writer asks for a receive page |
| rx_grant | output | 1 | A receive page may be taken this clock |
| rx_page | output | 2 | Page handed out on a receive claim |
| irq | output | 1 | Interrupt line |

## Verification
The hardest state to reach is a pending transmit allocation that meets a freeing event. That event can be a release command, a receive pop with release, or an auto-release completion. It must arrive while the receive port is also asking for pages, because the block must give the freed page to the pending allocation and not to the receiver. The stimulus fills all four pages, issues a failing allocation, frees pages through each path in turn, and then runs a long random mix of commands, acknowledges and receive requests. A behavioural model with plain queues follows every clock of that mix.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

    localparam logic [7:0] ALLOC_FAIL = 8'h80;
    localparam logic [7:0] ACK_CLEARABLE = 8'hD6;

    localparam int ST_ALLOC   = 3;
    localparam int ST_TXEMPTY = 2;
    localparam int ST_TXDONE  = 1;
    localparam int ST_RCV     = 0;

    typedef enum logic [2:0] {
        CMD_NOP      = 3'd0,
        CMD_ALLOC    = 3'd1,
        CMD_RESET    = 3'd2,
        CMD_RXPOP    = 3'd3,
        CMD_RXPOPREL = 3'd4,
        CMD_RELEASE  = 3'd5,
        CMD_TXQUEUE  = 3'd6,
        CMD_TXRESET  = 3'd7
    } mmu_cmd_e;

    typedef enum logic [3:0] {
        RA_CMD   = 4'd0,
        RA_PNUM  = 4'd1,
        RA_ARES  = 4'd2,
        RA_DONE  = 4'd3,
        RA_RXHD  = 4'd4,
        RA_ISTAT = 4'd5,
        RA_IMASK = 4'd6,
        RA_CTRL  = 4'd7,
        RA_USED  = 4'd8,
        RA_SIZE  = 4'd9
    } reg_addr_e;

    typedef struct packed {
        logic auto_rel;
        logic tx_en;
    } ctrl_t;

    function automatic logic [7:0] queue_head_byte(input logic empty, input logic [7:0] head);
        return empty ? ALLOC_FAIL : head;
    endfunction

endpackage

// File: rtl/page_alloc.sv
module page_alloc #(
    parameter int NUM_PAGES = 4,
    localparam int IDX_W = $clog2(NUM_PAGES),
    localparam int CNT_W = $clog2(NUM_PAGES + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 alloc_en,
    input  logic                 clr_all,
    input  logic [NUM_PAGES-1:0] rel_mask,
    output logic                 free_any,
    output logic [IDX_W-1:0]     free_idx,
    output logic [CNT_W-1:0]     used_cnt
);

    logic [NUM_PAGES-1:0] used_map;
    logic [NUM_PAGES-1:0] take_mask;

    always_comb begin
        free_idx = '0;
        for (int i = NUM_PAGES - 1; i >= 0; i--) begin
            if (!used_map[i]) free_idx = IDX_W'(i);
        end
        free_any = ~&used_map;
        used_cnt = '0;
        for (int i = 0; i < NUM_PAGES; i++) begin
            used_cnt = used_cnt + CNT_W'(used_map[i]);
        end
        take_mask = '0;
        if (alloc_en && free_any) take_mask[free_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_all) used_map <= '0;
        else                used_map <= (used_map & ~rel_mask) | take_mask;
    end

    AST_LOWEST_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (alloc_en && free_any && !clr_all) |=> (used_cnt != '0)) // R1
        else $error("allocation left no page used");

endmodule

// File: rtl/page_fifo.sv
module page_fifo #(
    parameter int DEPTH = 4,
    parameter int W = 2,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] cnt
);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic          push_ok, pop_ok;

    assign push_ok = push && (cnt != CW'(DEPTH));
    assign pop_ok  = pop && (cnt != '0);
    assign head    = mem[rd_ptr];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= step(wr_ptr);
            end
            if (pop_ok) rd_ptr <= step(rd_ptr);
            cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    AST_PUSH_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        (push && !clr && cnt == '0) |=> (cnt != '0)) // R8
        else $error("pushed entry not visible");

endmodule

// File: rtl/pkt_page_mgr.sv
module pkt_page_mgr #(
    parameter int NUM_PAGES = 4,
    localparam int IDX_W = $clog2(NUM_PAGES),
    localparam int CNT_W = $clog2(NUM_PAGES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [3:0]       wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [3:0]       rd_addr,
    output logic [7:0]       rd_data,
    input  logic             rx_req,
    output logic             rx_grant,
    output logic [IDX_W-1:0] rx_page,
    output logic             irq
);
    import ppm_pkg::*;

    ctrl_t             ctrl_q;
    logic [IDX_W-1:0]  pnum_q;
    logic [7:0]        ares_q, stat_q, mask_q, stat_d, ares_d, istat_vis, lvl;
    mmu_cmd_e          cmd;
    logic              cmd_wr, ack_wr, clr_tx, clr_all, drain, retry_now, rx_take, alloc_en;
    logic              free_any;
    logic [IDX_W-1:0]  free_idx;
    logic [CNT_W-1:0]  used_cnt, txq_cnt, done_cnt, rx_cnt;
    logic [IDX_W-1:0]  txq_head, done_head, rx_head;
    logic              txq_empty, done_empty, rx_empty, rx_pop;
    logic [NUM_PAGES-1:0] rel_mask;

    assign cmd_wr   = wr_en && (wr_addr == RA_CMD);
    assign cmd      = mmu_cmd_e'(wr_data[7:5]);
    assign ack_wr   = wr_en && (wr_addr == RA_ISTAT);
    assign clr_all  = cmd_wr && (cmd == CMD_RESET);
    assign clr_tx   = cmd_wr && (cmd == CMD_RESET || cmd == CMD_TXRESET);
    assign rx_pop   = cmd_wr && (cmd == CMD_RXPOP || cmd == CMD_RXPOPREL);

    assign txq_empty  = (txq_cnt == '0);
    assign done_empty = (done_cnt == '0);
    assign rx_empty   = (rx_cnt == '0);

    assign drain     = ctrl_q.tx_en && !txq_empty && !clr_tx;
    assign retry_now = (ares_q == ALLOC_FAIL) && free_any && !wr_en;
    assign rx_grant  = !wr_en && free_any && (rx_cnt != CNT_W'(NUM_PAGES)) && !retry_now;
    assign rx_take   = rx_req && rx_grant;
    assign rx_page   = free_idx;
    assign alloc_en  = rx_take || retry_now || (cmd_wr && cmd == CMD_ALLOC);

    always_comb begin
        rel_mask = '0;
        if (cmd_wr && cmd == CMD_RELEASE) rel_mask[pnum_q] = 1'b1;
        if (cmd_wr && cmd == CMD_RXPOPREL && !rx_empty) rel_mask[rx_head] = 1'b1;
        if (drain && ctrl_q.auto_rel) rel_mask[txq_head] = 1'b1;
    end

    page_alloc #(.NUM_PAGES(NUM_PAGES)) u_alloc (
        .clk(clk), .rst(rst), .alloc_en(alloc_en), .clr_all(clr_all),
        .rel_mask(rel_mask), .free_any(free_any), .free_idx(free_idx), .used_cnt(used_cnt)
    );

    page_fifo #(.DEPTH(NUM_PAGES), .W(IDX_W)) u_txq (
        .clk(clk), .rst(rst), .clr(clr_tx),
        .push(cmd_wr && cmd == CMD_TXQUEUE), .din(pnum_q),
        .pop(drain), .head(txq_head), .cnt(txq_cnt)
    );

    page_fifo #(.DEPTH(NUM_PAGES), .W(IDX_W)) u_doneq (
        .clk(clk), .rst(rst), .clr(clr_tx),
        .push(drain && !ctrl_q.auto_rel), .din(txq_head),
        .pop(ack_wr && wr_data[ST_TXDONE]), .head(done_head), .cnt(done_cnt)
    );

    page_fifo #(.DEPTH(NUM_PAGES), .W(IDX_W)) u_rxq (
        .clk(clk), .rst(rst), .clr(clr_all),
        .push(rx_take), .din(free_idx),
        .pop(rx_pop), .head(rx_head), .cnt(rx_cnt)
    );

    always_comb begin
        lvl = '0;
        lvl[ST_TXEMPTY] = txq_empty;
        lvl[ST_TXDONE]  = !done_empty;
        istat_vis = stat_q | lvl;

        stat_d = istat_vis;
        if (cmd_wr && cmd == CMD_ALLOC) stat_d[ST_ALLOC] = 1'b0;
        if ((cmd_wr && cmd == CMD_ALLOC && free_any) || retry_now) stat_d[ST_ALLOC] = 1'b1;
        if (rx_take) stat_d[ST_RCV] = 1'b1;
        if (rx_pop)  stat_d[ST_RCV] = !rx_empty && (rx_cnt > CNT_W'(1));
        if (ack_wr)  stat_d = stat_d & ~(wr_data & ACK_CLEARABLE);

        ares_d = ares_q;
        if (clr_all) ares_d = '0;
        else if (cmd_wr && cmd == CMD_ALLOC) ares_d = free_any ? 8'(free_idx) : ALLOC_FAIL;
        else if (retry_now) ares_d = 8'(free_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= 8'h04;
            ares_q <= '0;
            mask_q <= '0;
            pnum_q <= '0;
            ctrl_q <= '0;
        end else begin
            stat_q <= stat_d;
            ares_q <= ares_d;
            if (wr_en && wr_addr == RA_IMASK) mask_q <= wr_data;
            if (wr_en && wr_addr == RA_PNUM)  pnum_q <= wr_data[IDX_W-1:0];
            if (wr_en && wr_addr == RA_CTRL)  ctrl_q <= ctrl_t'(wr_data[1:0]);
        end
    end

    always_comb begin
        case (rd_addr)
            RA_PNUM:  rd_data = 8'(pnum_q);
            RA_ARES:  rd_data = ares_q;
            RA_DONE:  rd_data = queue_head_byte(done_empty, 8'(done_head));
            RA_RXHD:  rd_data = queue_head_byte(rx_empty, 8'(rx_head));
            RA_ISTAT: rd_data = istat_vis;
            RA_IMASK: rd_data = mask_q;
            RA_CTRL:  rd_data = 8'(ctrl_q);
            RA_USED:  rd_data = 8'(used_cnt);
            RA_SIZE:  rd_data = 8'(NUM_PAGES);
            default:  rd_data = 8'h00;
        endcase
    end

    assign irq = |(istat_vis & mask_q);

    AST_FULL_FAIL: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd == CMD_ALLOC && !free_any) |=> (ares_q == ALLOC_FAIL && !stat_q[ST_ALLOC])) // R2
        else $error("failed allocation not reported");

    AST_RETRY_FIRES: assert property (@(posedge clk) disable iff (rst)
        (ares_q == ALLOC_FAIL && free_any && !wr_en) |=> (ares_q != ALLOC_FAIL && stat_q[ST_ALLOC])) // R4
        else $error("pending allocation not retried");

    AST_RX_CLAIM: assert property (@(posedge clk) disable iff (rst)
        rx_take |=> (!rx_empty && stat_q[ST_RCV])) // R10
        else $error("receive claim not queued");

endmodule

// File: tb/tb_pkt_page_mgr.sv
module tb_pkt_page_mgr;
    localparam int NP = 4;

    logic       clk = 1'b0, rst = 1'b1;
    logic       wr_en = 1'b0, rx_req = 1'b0;
    logic [3:0] wr_addr = '0, rd_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       rx_grant, irq;
    logic [1:0] rx_page;

    always #4 clk = ~clk;

    pkt_page_mgr #(.NUM_PAGES(NP)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .rx_req(rx_req), .rx_grant(rx_grant),
        .rx_page(rx_page), .irq(irq)
    );

    int n_run = 0, n_fail = 0, cyc = 0;
    bit finished = 0;

    // behavioural reference
    int m_map, m_ares, m_stat, m_mask, m_pnum, m_txen, m_auto;
    int txq[$], dq[$], rq[$];

    function automatic int m_low();
        for (int i = 0; i < NP; i++) if (((m_map >> i) & 1) == 0) return i;
        return 0;
    endfunction
    function automatic bit m_free(); return m_map != ((1 << NP) - 1); endfunction
    function automatic bit m_retry(bit wr); return m_ares == 128 && m_free() && !wr; endfunction
    function automatic bit m_grant(bit wr);
        return !wr && m_free() && rq.size() < NP && !m_retry(wr);
    endfunction
    function automatic int m_vis();
        return m_stat | (txq.size() == 0 ? 4 : 0) | (dq.size() != 0 ? 2 : 0);
    endfunction
    function automatic int m_read(int a);
        int c;
        case (a)
            1: return m_pnum;
            2: return m_ares;
            3: return dq.size() == 0 ? 128 : dq[0];
            4: return rq.size() == 0 ? 128 : rq[0];
            5: return m_vis();
            6: return m_mask;
            7: return (m_auto << 1) | m_txen;
            8: begin c = 0; for (int i = 0; i < NP; i++) c += (m_map >> i) & 1; return c; end
            9: return NP;
            default: return 0;
        endcase
    endfunction
    function automatic string tag_of(int a);
        case (a)
            0: return "R9 busy";   1: return "R3 pnum";  2: return "R2 alloc result";
            3: return "R6 done head"; 4: return "R8 rx head"; 5: return "R5 status";
            6: return "R5 mask";   7: return "R7 ctrl";  8: return "R9 used";
            9: return "R9 size";   default: return "R12 unused addr";
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic model_reset();
        m_map = 0; m_ares = 0; m_stat = 4; m_mask = 0; m_pnum = 0; m_txen = 0; m_auto = 0;
        txq.delete(); dq.delete(); rq.delete();
    endtask

    task automatic model_step(bit wr, int a, int d, bit rin);
        int pre_tx = txq.size(), pre_done = dq.size(), pre_rx = rq.size();
        bit fa = m_free();
        int low = m_low();
        bit retry = m_retry(wr);
        bit take = rin && m_grant(wr);
        int ns = m_vis(), add = 0, rel = 0, nares = m_ares, h;
        int cmd = (wr && a == 0) ? ((d >> 5) & 7) : 0;
        bit clrtx = wr && a == 0 && (cmd == 2 || cmd == 7);
        if (take) begin add = 1 << low; rq.push_back(low); ns |= 1; end
        if (retry) begin add = 1 << low; nares = low; ns |= 8; end
        if (m_txen && pre_tx > 0 && !clrtx) begin
            h = txq.pop_front();
            if (m_auto) rel |= 1 << h;
            else if (pre_done < NP) dq.push_back(h);
        end
        if (wr) begin
            case (a)
                0: case (cmd)
                    1: begin
                        ns &= ~8;
                        if (fa) begin add = 1 << low; nares = low; ns |= 8; end
                        else nares = 128;
                    end
                    2: begin txq.delete(); dq.delete(); rq.delete(); nares = 0; end
                    3, 4: if (pre_rx > 0) begin
                        if (cmd == 4) rel |= 1 << rq[0];
                        void'(rq.pop_front());
                        ns = (rq.size() > 0) ? (ns | 1) : (ns & ~1);
                    end else ns &= ~1;
                    5: rel |= 1 << m_pnum;
                    6: if (pre_tx < NP) txq.push_back(m_pnum);
                    7: begin txq.delete(); dq.delete(); end
                    default: ;
                endcase
                1: m_pnum = d % NP;
                5: begin
                    ns &= ~(d & 'hD6);
                    if ((d & 2) != 0 && pre_done > 0) void'(dq.pop_front());
                end
                6: m_mask = d & 255;
                7: begin m_txen = d & 1; m_auto = (d >> 1) & 1; end
                default: ;
            endcase
        end
        if (wr && a == 0 && cmd == 2) m_map = 0;
        else m_map = ((m_map & ~rel) | add) & ((1 << NP) - 1);
        m_stat = ns & 255;
        m_ares = nares;
    endtask

    task automatic tick(bit wr, int a, int d, bit rin);
        @(negedge clk);
        wr_en = wr; wr_addr = a[3:0]; wr_data = d[7:0]; rx_req = rin;
        rd_addr = 4'(cyc % 12);
        #1;
        check(tag_of(cyc % 12), rd_data, m_read(cyc % 12));
        check("R5 irq", irq, (m_vis() & m_mask) != 0);
        check("R10 rx_grant", rx_grant, m_grant(wr));
        if (m_grant(wr)) check("R1 rx_page", rx_page, m_low());
        @(posedge clk);
        model_step(wr, a, d, rin);
        cyc++;
    endtask

    task automatic wr(int a, int d); tick(1, a, d, 0); endtask
    task automatic idle(int n); repeat (n) tick(0, 0, 0, 0); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        idle(12);                                  // reset values on every address (R9, R12)
        wr(6, 8'hFF);
        repeat (4) wr(0, 8'h20);                   // R1 lowest-first allocation
        wr(0, 8'h20); idle(2);                     // R2 failure leaves 0x80
        wr(1, 2); wr(0, 8'hA0); idle(3);           // R4 retry after release
        wr(1, 1); wr(0, 8'hA0); wr(1, 3); wr(0, 8'hA0);
        tick(0, 0, 0, 1); tick(0, 0, 0, 1); tick(0, 0, 0, 1); // R10 receive claims
        wr(0, 8'h60); wr(0, 8'h80); wr(0, 8'h80); idle(2);   // R8 pops, including empty
        wr(1, 0); wr(0, 8'hC0); wr(1, 2); wr(0, 8'hC0); idle(2);
        wr(7, 1); idle(3);                         // R7 completion to done queue
        wr(5, 8'h02); idle(1); wr(5, 8'hFF); idle(2); // R6 acknowledge pops
        wr(7, 3); wr(1, 0); wr(0, 8'hC0); idle(3); // R7 auto-release
        wr(0, 8'hE0); wr(0, 8'h40); idle(4);       // R11 queue and full resets
        wr(11, 8'h55); wr(13, 8'hAA); idle(12);    // R12 unused addresses
        repeat (3000) begin
            int r = $urandom % 11;
            if (r < 4)       wr(0, int'($urandom % 8) << 5);   // R3 command mix
            else if (r == 4) wr(1, $urandom % 256);
            else if (r == 5) wr(5, $urandom % 256);
            else if (r == 6) wr(7, $urandom % 4);
            else if (r == 7) wr(6, $urandom % 256);
            else if (r == 8) wr($urandom % 16, $urandom % 256);
            else             tick(0, 0, 0, 1'($urandom % 2));
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule